// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block is a per-channel clock divider. It turns a chosen counting clock into a square-wave baud clock whose period is set by a 16-bit time constant. Software loads the time constant as two separately written bytes through a small register port, and it can read each byte back. The counting clock is either every cycle of the system clock or every rising edge of an external pin clock. The pin clock is synchronised into the system clock domain, so all logic runs on one clock.

While disabled, the generator holds its output high and keeps the counter loaded. Once enabled, each counting tick does one of three things:

- it reloads the counter from the time constant,
- it decrements a non-zero count, or
- at zero, it toggles the output and arms a reload for the next tick.

Each half-period of the output therefore lasts the time constant plus two counting ticks.

Top module: `baud_gen`

## Requirements
- R1: A write with `addr`=0 stores `wr_data` in bits 7:0 of the time constant, and a write with `addr`=1 stores it in bits 15:8. The other byte is left unchanged. Both bytes reset to 0.
- R2: `rd_data` shows bits 7:0 of the time constant when `addr`=0 and bits 15:8 when `addr`=1, in the same cycle.
- R3: While enabled, each counting tick that is neither a reload tick nor a tick at zero decrements the 16-bit counter by one.
- R4: While `enable` is low, `baud_out` is high from the next clock onward, and the counter is held at the time constant.
- R5: While enabled, every half-period of `baud_out` lasts exactly (time constant + 2) counting ticks. This includes the first half-period after `enable` rises, which starts with a reload tick.
- R6: A time-constant write made after a reload takes effect at the next reload. The half-period in progress keeps its length.
- R7: With `src_sel`=0, every system clock cycle is a counting tick, and activity on `ext_clk` has no effect.
- R8: With `src_sel`=1, only rising edges of `ext_clk` are counting ticks. They are seen after a two-flop synchroniser, and the output holds between ticks.
- R9: Changing `src_sel` or toggling `ext_clk` while disabled leaves `baud_out` high with no glitch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | Byte select: 0 low, 1 high |
| wr_en | input | 1 | Write strobe for the selected byte |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Read-back of the selected byte |
| enable | input | 1 | Run the generator when high |
| src_sel | input | 1 | Counting clock: 0 system clock, 1 external pin |
| ext_clk | input | 1 | External pin clock, asynchronous |
| baud_out | output | 1 | Square-wave baud clock |

## Verification
The hardest case to reach from the ports is a time-constant change that arrives after the reload of the current half-period but before its terminal count. The bench places it exactly there: it waits for an output edge, lets four system clocks pass while the generator runs from the system clock, and then writes a smaller constant. It then checks that the remaining part of the old half-period is unchanged and that the following half-period uses the new value. The external-clock path is handled the same way. The bench ignores the first half-period, which includes synchroniser latency, and measures later half-periods as multiples of the pin-clock period.

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter logic [15:0] RESET_TC = 16'h0000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       enable,
  input  logic       src_sel,
  input  logic       ext_clk,
  output logic       baud_out
);

  logic [15:0] tc;
  logic [15:0] cnt;
  logic        reload_due;
  logic [2:0]  ext_sync;
  logic        tick;

  assign rd_data = addr ? tc[15:8] : tc[7:0];
  assign tick    = src_sel ? (ext_sync[1] & ~ext_sync[2]) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc <= RESET_TC;
    end else if (wr_en) begin
      if (addr) tc[15:8] <= wr_data;
      else      tc[7:0]  <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sync <= '0;
    else        ext_sync <= {ext_sync[1:0], ext_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= RESET_TC;
      baud_out   <= 1'b1;
      reload_due <= 1'b1;
    end else if (!enable) begin
      cnt        <= tc;
      baud_out   <= 1'b1;
      reload_due <= 1'b1;
    end else if (tick) begin
      if (reload_due) begin
        cnt        <= tc;
        reload_due <= 1'b0;
      end else if (cnt == 16'd0) begin
        baud_out   <= ~baud_out;
        reload_due <= 1'b1;
      end else begin
        cnt <= cnt - 16'd1;
      end
    end
  end

endmodule

module baud_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        tick,
  input logic        reload_due,
  input logic [15:0] cnt,
  input logic [15:0] tc,
  input logic        baud_out
);

  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> baud_out);

  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && !reload_due && cnt != 16'd0) |=> cnt == $past(cnt) - 16'd1);

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && reload_due) |=> cnt == $past(tc));

  p_toggle_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !$stable(baud_out)) |-> ($past(cnt) == 16'd0 && !$past(reload_due)));

  p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> ($stable(cnt) && $stable(baud_out)));

endmodule

bind baud_gen baud_gen_chk u_baud_gen_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
  .reload_due(reload_due), .cnt(cnt), .tc(tc), .baud_out(baud_out)
);

// File: tb/baud_gen_bench.sv
`timescale 1ns/1ps
module baud_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       enable = 1'b0;
  logic       src_sel = 1'b0;
  logic       ext_clk = 1'b0;
  logic       ext_run = 1'b0;
  logic       baud_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  baud_gen u_baud_gen (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .enable(enable), .src_sel(src_sel), .ext_clk(ext_clk),
    .baud_out(baud_out)
  );

  initial begin
    forever begin
      repeat (4) @(negedge clk);
      if (ext_run) ext_clk = ~ext_clk;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_tc(input logic [15:0] v);
    wr_byte(1'b0, v[7:0]);
    wr_byte(1'b1, v[15:8]);
  endtask

  task automatic wait_toggle(output int n);
    logic prev;
    prev = baud_out;
    n = 0;
    while (baud_out == prev && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    check("R4 reset out high", baud_out, 1);
    addr = 1'b0; #1;
    check("R1 reset low byte", rd_data, 0);
    addr = 1'b1; #1;
    check("R1 reset high byte", rd_data, 0);
  endtask

  task automatic t_regs();
    wr_byte(1'b0, 8'hA5);
    wr_byte(1'b1, 8'h3C);
    addr = 1'b0; #1;
    check("R2 read low", rd_data, 8'hA5);
    addr = 1'b1; #1;
    check("R2 read high", rd_data, 8'h3C);
    wr_byte(1'b0, 8'h11);
    addr = 1'b1; #1;
    check("R1 high unchanged", rd_data, 8'h3C);
    addr = 1'b0; #1;
    check("R1 low updated", rd_data, 8'h11);
  endtask

  task automatic t_idle();
    int bad = 0;
    set_tc(16'd3);
    enable = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (baud_out !== 1'b1) bad++;
    end
    check("R4 idle stays high", bad, 0);
  endtask

  task automatic t_sys(input logic [15:0] v);
    int n;
    src_sel = 1'b0;
    set_tc(v);
    enable = 1'b1;
    wait_toggle(n);
    check("R5 first half", n, v + 2);
    check("R5 first edge falls", baud_out, 0);
    wait_toggle(n);
    check("R5 second half", n, v + 2);
    wait_toggle(n);
    check("R5 third half", n, v + 2);
    enable = 1'b0;
    @(negedge clk);
    check("R4 disable forces high", baud_out, 1);
  endtask

  task automatic t_midrun_write();
    int n;
    src_sel = 1'b0;
    set_tc(16'd10);
    enable = 1'b1;
    wait_toggle(n);
    repeat (3) @(negedge clk);
    wr_byte(1'b0, 8'd3);
    wait_toggle(n);
    check("R6 current half undisturbed", n, 8);
    wait_toggle(n);
    check("R6 new constant at reload", n, 5);
    enable = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_ext_ignored();
    int n;
    ext_run = 1'b1;
    src_sel = 1'b0;
    set_tc(16'd4);
    enable = 1'b1;
    wait_toggle(n);
    wait_toggle(n);
    check("R7 ext activity ignored", n, 6);
    enable = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_ext();
    int n;
    ext_run = 1'b1;
    set_tc(16'd2);
    src_sel = 1'b1;
    enable = 1'b1;
    wait_toggle(n);
    wait_toggle(n);
    check("R8 ext half period", n, 32);
    wait_toggle(n);
    check("R8 ext half period again", n, 32);
    enable = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_sel_glitch();
    int bad = 0;
    ext_run = 1'b1;
    enable = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (i % 7 == 0) src_sel = ~src_sel;
      @(negedge clk);
      if (baud_out !== 1'b1) bad++;
    end
    check("R9 no glitch while disabled", bad, 0);
    src_sel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_regs();
    t_idle();
    t_sys(16'd5);
    t_sys(16'd0);
    t_sys(16'h0100);
    t_midrun_write();
    t_ext_ignored();
    t_ext();
    t_sel_glitch();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule